// File: doc/BRIEF.md
# NAND Read Prefetch Engine

This block sits between a host register bus and a byte-wide NAND data port. Software programs a byte count, a chip select and a FIFO threshold, then starts the engine. The engine pulls bytes from the NAND port, one handshake per byte, into a 64-byte internal FIFO ahead of the host. The host then drains the FIFO through a data register, one 32-bit word at a time. Each word carries four FIFO bytes. The oldest byte goes in bits 7:0.

A status register reports how many bytes are still to be fetched and how many sit in the FIFO. When the FIFO is full, the engine pauses fetching and resumes once a word read frees space. A data read issued with fewer than four bytes in the FIFO is held off through a ready output. The control register reads 1 while a transfer is active. It refuses a second start in that state, and it clears itself once every byte has been fetched and drained. Writing a value with bit 0 clear to the control register aborts the transfer and empties the FIFO.

Top module: `nand_prefetch_eng`

## Requirements
- R1: After reset, every register reads 0 and `nand_req` is low.
- R2: Register addresses are 0 (setup), 1 (count), 2 (control), 3 (status) and 4 (data). The setup register holds these fields:
  - bit 0: direction, where 0 means read prefetch.
  - bit 7: enable.
  - bits 14:8: FIFO threshold.
  - bits 24 and up: chip select, which drives `nand_cs`.
  The setup register reads back these fields and 0 in every other bit. The count register holds the byte count in bits 13:0.
- R3: A threshold value written above 0x40 reads back as 0x40. Values up to 0x40 are kept as written.
- R4: Writing the control register with bit 0 set starts a transfer only when the control register reads 0, enable is 1 and direction is 0. A start makes the control register read 1 and loads the remaining count from the count register. A start request that fails any of these conditions leaves the control register at 0.
- R5: While a transfer is active, a control write with bit 0 set does not reload the remaining count. Writes to the setup and count registers are ignored.
- R6: A fetch raises `nand_req` and holds it until `nand_ack`. Each accepted byte lowers the remaining count by one and adds one byte to the FIFO occupancy.
- R7: The FIFO holds at most 64 bytes. At that occupancy `nand_req` stays low. Fetching resumes after a word is read out.
- R8: A data register read returns the four oldest FIFO bytes packed little-endian: the oldest byte is in bits 7:0. The read removes those four bytes. With fewer than four bytes stored, `csr_ready` is low for a data read and nothing is removed.
- R9: The status register reports the remaining count in bits 13:0 and the FIFO occupancy in bits 30:24. All other status bits are 0.
- R10: The control register returns to 0 on its own once the remaining count is 0, the FIFO is empty and no fetch is pending. A start with a count of 0 reads 1 for one cycle, then 0.
- R11: A control write with bit 0 clear stops the transfer. On the next cycle the control register reads 0, the status register reads 0 and `nand_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_re | input | 1 | Register read strobe; consumes FIFO data at address 4 |
| csr_addr | input | 3 | Register address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the addressed register (combinational) |
| csr_ready | output | 1 | Low when a data read must wait for four stored bytes |
| nand_req | output | 1 | Byte fetch request, held until acknowledged |
| nand_ack | input | 1 | NAND byte valid; accepted while `nand_req` is high |
| nand_din | input | 8 | NAND byte |
| nand_cs | output | 3 | Programmed chip select |

## Verification
The assertions check several rules on every cycle:
- The FIFO never exceeds 64 bytes, and no fetch is requested while it is full.
- A request holds until it is acknowledged or the transfer is aborted.
- No request appears while the engine is idle.
- The remaining count never rises during a transfer.
- A stalled data read never removes bytes.
- An abort empties the FIFO and the count on the next cycle.

Only the bench scenarios can show the rest:
- The byte order inside each word and the exact data sequence.
- Threshold clamping and register readback.
- A start refused for a disabled or write-direction setup, or while a transfer is active.
- Self-clearing after the last drain.
- A partial final word that stalls until an abort.

// File: rtl/npf_pkg.sv
package npf_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_SETUP = 3'd0;
   localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
   localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
   localparam logic [ADDR_W-1:0] A_DATA  = 3'd4;

   localparam int DIR_BIT  = 0;
   localparam int EN_BIT   = 7;
   localparam int THR_LSB  = 8;
   localparam int THR_W    = 7;
   localparam int CS_LSB   = 24;
   localparam int OCC_LSB  = 24;
   localparam int LANES    = 4;

   typedef struct packed {
      logic [THR_W-1:0] thr;
      logic             en;
      logic             dir;
   } setup_t;
endpackage

// File: rtl/npf_regs.sv
module npf_regs
   import npf_pkg::*;
#(
   parameter int CNT_W   = 14,
   parameter int CS_W    = 3,
   parameter int OCC_W   = 7,
   parameter int THR_MAX = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic              rem_zero,
   input  logic              fetch_idle,
   input  logic [OCC_W-1:0]  occ,
   output setup_t            setup,
   output logic [CS_W-1:0]   cs,
   output logic [CNT_W-1:0]  count,
   output logic              running,
   output logic              start,
   output logic              stop
);
   localparam logic [THR_W-1:0] THR_CAP = THR_W'(THR_MAX);

   logic             ctrl_wr, setup_wr, count_wr, done;
   logic [THR_W-1:0] thr_in;

   assign ctrl_wr  = we && (addr == A_CTRL);
   assign setup_wr = we && (addr == A_SETUP) && !running;
   assign count_wr = we && (addr == A_COUNT) && !running;
   assign start    = ctrl_wr && wdata[0] && !running && setup.en && !setup.dir;
   assign stop     = ctrl_wr && !wdata[0];
   assign done     = running && rem_zero && fetch_idle && (occ == '0);
   assign thr_in   = wdata[THR_LSB +: THR_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         setup <= '0;
         cs    <= '0;
      end else if (setup_wr) begin
         setup.dir <= wdata[DIR_BIT];
         setup.en  <= wdata[EN_BIT];
         setup.thr <= (thr_in > THR_CAP) ? THR_CAP : thr_in;
         cs        <= wdata[CS_LSB +: CS_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        count <= '0;
      else if (count_wr) count <= wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     running <= 1'b0;
      else if (stop)  running <= 1'b0;
      else if (start) running <= 1'b1;
      else if (done)  running <= 1'b0;
   end
endmodule

// File: rtl/npf_fetch.sv
module npf_fetch #(
   parameter int CNT_W = 14,
   parameter int DEPTH = 64,
   parameter int OCC_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             running,
   input  logic [CNT_W-1:0] load_count,
   input  logic [OCC_W-1:0] occ,
   input  logic             nand_ack,
   input  logic [7:0]       nand_din,
   output logic             nand_req,
   output logic             push,
   output logic [7:0]       push_data,
   output logic [CNT_W-1:0] rem
);
   logic space;

   assign space     = int'(occ) < DEPTH;
   assign push      = nand_req && nand_ack && !stop;
   assign push_data = nand_din;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nand_req <= 1'b0;
         rem      <= '0;
      end else if (stop) begin
         nand_req <= 1'b0;
         rem      <= '0;
      end else if (start) begin
         nand_req <= 1'b0;
         rem      <= load_count;
      end else if (nand_req && nand_ack) begin
         nand_req <= 1'b0;
         rem      <= rem - 1'b1;
      end else if (!nand_req && running && (rem != '0) && space) begin
         nand_req <= 1'b1;
      end
   end
endmodule

// File: rtl/npf_fifo.sv
module npf_fifo #(
   parameter int DEPTH = 64,
   parameter int LANES = 4,
   parameter int OCC_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               push,
   input  logic [7:0]         push_data,
   input  logic               pop,
   output logic [OCC_W-1:0]   occ,
   output logic [8*LANES-1:0] word
);
   localparam int PTR_W = $clog2(DEPTH);

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic             push_ok, pop_ok;

   assign push_ok = push && (int'(occ) < DEPTH);
   assign pop_ok  = pop && (int'(occ) >= LANES);

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wptr <= '0;
         rptr <= '0;
         occ  <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + PTR_W'(LANES);
         occ <= occ + OCC_W'(push_ok) - (pop_ok ? OCC_W'(LANES) : '0);
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign word[8*g +: 8] = mem[rptr + PTR_W'(g)];
   end
endmodule

// File: rtl/nand_prefetch_eng.sv
module nand_prefetch_eng
   import npf_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int CNT_W   = 14,
   parameter int CS_W    = 3,
   parameter int THR_MAX = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic              csr_re,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   output logic              csr_ready,
   output logic              nand_req,
   input  logic              nand_ack,
   input  logic [7:0]        nand_din,
   output logic [CS_W-1:0]   nand_cs
);
   localparam int OCC_W = $clog2(DEPTH) + 1;

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < LANES) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least four");
   end
   if (OCC_W > 7) begin : g_bad_occ
      $error("FIFO occupancy must fit in seven status bits");
   end
   if (CNT_W < 1 || CNT_W > 14) begin : g_bad_cnt
      $error("CNT_W must be 1 to 14");
   end
   if (CS_W < 1 || CS_W > 8) begin : g_bad_cs
      $error("CS_W must be 1 to 8");
   end
   if (THR_MAX < 1 || THR_MAX > 127) begin : g_bad_thr
      $error("THR_MAX must fit in the threshold field");
   end

   setup_t             setup;
   logic [CNT_W-1:0]   count, rem;
   logic [OCC_W-1:0]   occ;
   logic [8*LANES-1:0] word;
   logic               running, start, stop, push, pop;
   logic [7:0]         push_data;

   npf_regs #(.CNT_W(CNT_W), .CS_W(CS_W), .OCC_W(OCC_W), .THR_MAX(THR_MAX)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(csr_we), .addr(csr_addr), .wdata(csr_wdata),
      .rem_zero(rem == '0), .fetch_idle(!nand_req), .occ(occ),
      .setup(setup), .cs(nand_cs), .count(count), .running(running),
      .start(start), .stop(stop)
   );

   npf_fetch #(.CNT_W(CNT_W), .DEPTH(DEPTH), .OCC_W(OCC_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .running(running),
      .load_count(count), .occ(occ), .nand_ack(nand_ack), .nand_din(nand_din),
      .nand_req(nand_req), .push(push), .push_data(push_data), .rem(rem)
   );

   npf_fifo #(.DEPTH(DEPTH), .LANES(LANES), .OCC_W(OCC_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(stop), .push(push), .push_data(push_data),
      .pop(pop), .occ(occ), .word(word)
   );

   assign csr_ready = (csr_addr != A_DATA) || (int'(occ) >= LANES);
   assign pop       = csr_re && (csr_addr == A_DATA) && csr_ready;

   always_comb begin
      csr_rdata = '0;
      case (csr_addr)
         A_SETUP: begin
            csr_rdata[DIR_BIT]            = setup.dir;
            csr_rdata[EN_BIT]             = setup.en;
            csr_rdata[THR_LSB +: THR_W]   = setup.thr;
            csr_rdata[CS_LSB +: CS_W]     = nand_cs;
         end
         A_COUNT: csr_rdata[CNT_W-1:0] = count;
         A_CTRL:  csr_rdata[0]         = running;
         A_STAT: begin
            csr_rdata[CNT_W-1:0]          = rem;
            csr_rdata[OCC_LSB +: OCC_W]   = occ;
         end
         A_DATA:  csr_rdata[8*LANES-1:0] = word;
         default: csr_rdata = '0;
      endcase
   end
endmodule

// File: rtl/npf_chk.sv
module npf_chk #(
   parameter int DEPTH = 64,
   parameter int CNT_W = 14,
   parameter int OCC_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             csr_we,
   input logic             csr_re,
   input logic [2:0]       csr_addr,
   input logic [31:0]      csr_wdata,
   input logic             csr_ready,
   input logic             nand_req,
   input logic             nand_ack,
   input logic             running,
   input logic [OCC_W-1:0] occ,
   input logic [CNT_W-1:0] rem
);
   logic abort_w, stall_rd;
   assign abort_w  = csr_we && (csr_addr == 3'd2) && !csr_wdata[0];
   assign stall_rd = csr_re && (csr_addr == 3'd4) && !csr_ready;

   // R7
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= DEPTH);
   // R7
   full_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(occ) == DEPTH) |-> !nand_req);
   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nand_req && !nand_ack && !abort_w) |=> nand_req);
   // R10
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !nand_req);
   // R5
   rem_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> (rem <= $past(rem)));
   // R8
   stall_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_rd && !abort_w) |=> (occ >= $past(occ)));
   // R11
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_w |=> (occ == '0 && rem == '0 && !running && !nand_req));
endmodule

bind nand_prefetch_eng npf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_re(csr_re), .csr_addr(csr_addr),
   .csr_wdata(csr_wdata), .csr_ready(csr_ready), .nand_req(nand_req),
   .nand_ack(nand_ack), .running(running), .occ(occ), .rem(rem)
);

// File: tb/nand_prefetch_eng_tb.sv
module nand_prefetch_eng_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0, csr_re = 1'b0;
   logic [2:0]  csr_addr = 3'd0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        csr_ready, nand_req;
   logic        nand_ack = 1'b0;
   logic [7:0]  nand_din = 8'h00;
   logic [2:0]  nand_cs;

   int checks = 0, fails = 0;
   int byte_idx = 0, wait_cnt = 0;
   logic [7:0] pat_base = 8'h00;

   nand_prefetch_eng u_dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_re(csr_re), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_ready(csr_ready),
      .nand_req(nand_req), .nand_ack(nand_ack), .nand_din(nand_din), .nand_cs(nand_cs)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] pat(input int i);
      return 8'(i * 29 + int'(pat_base) + (i >> 3));
   endfunction

   function automatic logic [31:0] exp_word(input int k);
      return {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)};
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         nand_ack = 1'b0;
      end else if (nand_ack) begin
         nand_ack = 1'b0;
         wait_cnt = int'($urandom % 3);
      end else if (nand_req) begin
         if (wait_cnt == 0) begin
            nand_din = pat(byte_idx);
            nand_ack = 1'b1;
            byte_idx++;
         end else begin
            wait_cnt--;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_addr = a; csr_wdata = d; csr_we = 1'b1;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      csr_addr = a; csr_re = 1'b0;
      #1 d = csr_rdata;
   endtask

   task automatic rd_word(output logic [31:0] d);
      @(negedge clk);
      csr_addr = 3'd4; csr_re = 1'b1;
      #1;
      while (!csr_ready) begin
         @(negedge clk);
         #1;
      end
      d = csr_rdata;
      @(negedge clk);
      csr_re = 1'b0;
   endtask

   task automatic begin_xfer(input int cnt);
      wr(3'd0, 32'h0000_4080);
      wr(3'd1, 32'(cnt));
      pat_base = 8'($urandom);
      byte_idx = 0;
      wr(3'd2, 32'd1);
   endtask

   task automatic drain(input int words, input string tag, input bit rnd_gap);
      logic [31:0] d;
      for (int k = 0; k < words; k++) begin
         if (rnd_gap) repeat ($urandom % 6) @(negedge clk);
         rd_word(d);
         chk(tag, d, exp_word(k));
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, d); chk("R1 setup", d, 32'h0);
      rd(3'd1, d); chk("R1 count", d, 32'h0);
      rd(3'd2, d); chk("R1 ctrl", d, 32'h0);
      rd(3'd3, d); chk("R1 status", d, 32'h0);
      chk("R1 nand_req", 32'(nand_req), 32'h0);

      // R2 / R3 setup fields, clamp
      wr(3'd0, 32'h05FF_7F81);
      rd(3'd0, d); chk("R3 clamp readback", d, 32'h0500_4081);
      chk("R2 nand_cs", 32'(nand_cs), 32'h5);
      wr(3'd0, 32'h0000_4000);
      rd(3'd0, d); chk("R3 0x40 kept", d, 32'h0000_4000);
      wr(3'd1, 32'hFFFF_C123);
      rd(3'd1, d); chk("R2 count field", d, 32'h0000_0123);

      // R4 refused starts
      wr(3'd0, 32'h0000_2081);
      wr(3'd2, 32'd1);
      rd(3'd2, d); chk("R4 write-direction refused", d, 32'h0);
      wr(3'd0, 32'h0000_2000);
      wr(3'd2, 32'd1);
      rd(3'd2, d); chk("R4 disabled refused", d, 32'h0);

      // R10 zero count
      wr(3'd0, 32'h0000_0080);
      wr(3'd1, 32'd0);
      wr(3'd2, 32'd1);
      csr_addr = 3'd2; #1 chk("R10 zero count active one cycle", csr_rdata, 32'h1);
      @(negedge clk); #1 chk("R10 zero count self clear", csr_rdata, 32'h0);

      // R6 R8 R9 R10 small transfer
      begin_xfer(20);
      repeat (120) @(negedge clk);
      rd(3'd3, d); chk("R9 status after fill", d, {1'b0, 7'd20, 10'd0, 14'd0});
      drain(5, "R8 word order", 1'b0);
      repeat (2) @(negedge clk);
      rd(3'd2, d); chk("R10 self clear", d, 32'h0);
      rd(3'd3, d); chk("R6 status empty", d, 32'h0);

      // R5 restart and config ignored while running
      begin_xfer(100);
      repeat (10) @(negedge clk);
      wr(3'd1, 32'd5);
      wr(3'd2, 32'd1);
      wr(3'd0, 32'h0);
      rd(3'd0, d); chk("R5 setup unchanged", d, 32'h0000_4080);
      rd(3'd1, d); chk("R5 count unchanged", d, 32'd100);
      rd(3'd3, d); chk("R5 no reload", 32'(d[13:0] >= 80 && d[13:0] < 100), 32'h1);
      wr(3'd2, 32'd0);
      rd(3'd3, d); chk("R11 status cleared", d, 32'h0);
      rd(3'd2, d); chk("R11 ctrl cleared", d, 32'h0);
      chk("R11 nand_req low", 32'(nand_req), 32'h0);

      // R7 full FIFO
      begin_xfer(100);
      repeat (500) @(negedge clk);
      rd(3'd3, d); chk("R7 full status", d, {1'b0, 7'd64, 10'd0, 14'd36});
      chk("R7 no request when full", 32'(nand_req), 32'h0);
      drain(1, "R8 first word full", 1'b0);
      repeat (60) @(negedge clk);
      rd(3'd3, d); chk("R7 resumed", d, {1'b0, 7'd64, 10'd0, 14'd32});
      for (int k = 1; k < 25; k++) begin
         rd_word(d);
         chk("R8 full drain", d, exp_word(k));
      end
      repeat (3) @(negedge clk);
      rd(3'd2, d); chk("R10 clear after full run", d, 32'h0);

      // R8 stall with partial word, then R11 abort
      begin_xfer(6);
      repeat (60) @(negedge clk);
      rd(3'd3, d); chk("R9 six bytes", d, {1'b0, 7'd6, 10'd0, 14'd0});
      drain(1, "R8 partial run word", 1'b0);
      @(negedge clk);
      csr_addr = 3'd4; csr_re = 1'b1;
      #1 chk("R8 ready low", 32'(csr_ready), 32'h0);
      @(negedge clk);
      csr_re = 1'b0;
      rd(3'd3, d); chk("R8 stalled read keeps bytes", d, {1'b0, 7'd2, 10'd0, 14'd0});
      rd(3'd2, d); chk("R10 stays active with leftover", d, 32'h1);
      wr(3'd2, 32'd0);
      rd(3'd3, d); chk("R11 abort flush", d, 32'h0);
      rd(3'd2, d); chk("R11 abort ctrl", d, 32'h0);

      // Random transfers
      for (int t = 0; t < 8; t++) begin
         int cnt;
         cnt = 4 * (1 + int'($urandom % 40));
         begin_xfer(cnt);
         drain(cnt / 4, "R6 random run word", 1'b1);
         repeat (3) @(negedge clk);
         rd(3'd2, d); chk("R10 random self clear", d, 32'h0);
         rd(3'd3, d); chk("R9 random end status", d, 32'h0);
      end

      finish_run();
   end
endmodule